// File: doc/BRIEF.md
# Processor Suspend-by-Read Handshake Controller

This block sits in a compute node's bus control logic. It lets a host computer pause the node processor, which has no suspend input of its own. The processor pauses itself by reading one reserved mailbox word address. The controller does not forward that read to memory and does not complete it. Instead it hands the node bus to the host and raises a host-request flag. While the processor waits on the open read, the host may read and write node memory freely.

To resume the processor, the host writes a return word into the mailbox while the request flag is up, and then raises its done line. On the rising edge of done the controller completes the stalled read with the stored return word. It then returns the bus to the processor. Other processor accesses go straight through to memory with no added cycle. A separate halt input from the control register gives the host the bus at any time. Accesses from the processor are blocked while halt is asserted.

Top module: `rd_suspend_ctrl`

## Requirements
- R1: After a synchronous active-low reset the controller is idle: `host_req` and `bus_sel_host` are 0 (with `ctl_halt` low), and the stored return word is 0, so a suspension ended without any host write returns 0.
- R2: While idle and not halted, a processor read to any address other than `MBOX_ADDR`, or a processor write to any address, is forwarded in the same cycle: `mem_rd`/`mem_wr` follow the strobe, `cpu_rdy` equals `mem_rdy` and `cpu_rdata` equals `mem_rdata`. `cpu_rd` and `cpu_wr` are never both high.
- R3: A processor read to `MBOX_ADDR` is never forwarded (`mem_rd` stays 0), and `cpu_rdy` stays 0 until the completion cycle.
- R4: A mailbox read accepted while idle and not halted makes `bus_sel_host` 1 in the next cycle, with `host_req` still 0 (bus turnaround). In the cycle after that `host_req` becomes 1, and it stays 1 until a done edge is accepted.
- R5: `host_mbox_we` loads `host_wdata` into the return word only while `host_req` is 1. The last such write wins, and writes at any other time are ignored.
- R6: When `host_done` is 1 in a cycle where it was 0 in the cycle before, and `host_req` is 1, the next cycle is the single completion cycle. In that cycle `host_req` is 0, `cpu_rdy` is 1 and `cpu_rdata` is the return word, including a word written in the same cycle as the edge. In the following cycle the controller is idle.
- R7: A `host_done` level held high does not end a later suspension; a new 0-to-1 transition is needed.
- R8: While `ctl_halt` is 1, `bus_sel_host` is 1, nothing is forwarded to memory, `cpu_rdy` is 0 outside the completion cycle, and a mailbox read does not start a suspension.
- R9: Reset in any state returns the controller to idle, so in the next cycle `host_req` is 0 and the bus belongs to the processor.
- R10: The return word persists across suspensions: a suspension in which the host writes nothing returns the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rdy | output | 1 | Access completion to processor |
| cpu_rdata | output | DATA_W | Read data to processor |
| mem_rd | output | 1 | Forwarded read strobe to memory |
| mem_wr | output | 1 | Forwarded write strobe to memory |
| mem_rdy | input | 1 | Memory ready |
| mem_rdata | input | DATA_W | Memory read data |
| ctl_halt | input | 1 | Control-register halt, a second grant source |
| host_done | input | 1 | Host finished; rising edge resumes processor |
| host_mbox_we | input | 1 | Host write to the mailbox return word |
| host_wdata | input | DATA_W | Return word written by host |
| host_req | output | 1 | Suspension active, host may use the bus |
| bus_sel_host | output | 1 | Node bus owner: 1 host, 0 processor |

## Verification
The bench builds the controller with a 6-bit address, a 16-bit word and the mailbox at 0x2A. With this small address space the random mix hits the mailbox about one access in three, so complete suspensions happen many times. The 16-bit words still tell apart return words from memory data. Random stimulus also pulses halt and reset at low rates. These land inside the turnaround, waiting and completion cycles, and directed cases cover a held done level, a write in the same cycle as the done edge, and an empty suspension.

// File: rtl/susp_pkg.sv
// Shared types for the suspend-by-read controller.
package susp_pkg;

    // Controller phases; one completion cycle closes every suspension.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GRANT    = 2'd1,
        ST_WAIT     = 2'd2,
        ST_COMPLETE = 2'd3
    } susp_state_e;

endpackage

// File: rtl/susp_fsm.sv
// Suspension sequencer.
// Walks idle -> bus turnaround -> wait for host -> one completion cycle.
// Assumes trig_i is already qualified (idle, not halted, mailbox read).
// The done line is edge-detected here, so a held level cannot end two
// suspensions.
module susp_fsm
    import susp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_i,
    input  logic        done_i,
    output susp_state_e state_o
);

    susp_state_e state_q;
    susp_state_e state_d;
    logic        done_q;
    logic        done_rise;

    // Remember last cycle's done level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_i;
    end

    assign done_rise = done_i & ~done_q;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (trig_i)    state_d = ST_GRANT;
            ST_GRANT:                   state_d = ST_WAIT;
            ST_WAIT:     if (done_rise) state_d = ST_COMPLETE;
            ST_COMPLETE:                state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // A fresh done edge while waiting must close the suspension.
    assert_done_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && done_i && !done_q) |=> (state_q == ST_COMPLETE));

    // A done level carried over from the previous cycle must not complete.
    assert_level_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && done_i && $past(done_i)) |=> (state_q == ST_WAIT));

    // Completion never lasts longer than one cycle.
    assert_single_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPLETE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/susp_status_reg.sv
// Return-word holder.
// Captures the host's mailbox write only while the suspension is visible
// to the host, and keeps it otherwise. Later host traffic cannot change
// the word handed back to the processor.
module susp_status_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] word_q;

    // Load on an accepted host mailbox write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 word_q <= '0;
        else if (we_i && accept_i)  word_q <= wdata_i;
    end

    assign word_o = word_q;

    // An accepted write lands in the word.
    assert_status_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && accept_i) |=> (word_q == $past(wdata_i)));

    // Without an accepted write the word stays put.
    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && accept_i) |=> $stable(word_q));

endmodule

// File: rtl/susp_bus_path.sv
// Processor-side access path and bus ownership.
// Forwards ordinary accesses without delay while idle and not halted. It
// holds back mailbox reads and raises the suspension trigger for them, and
// it chooses read data and ready for the processor. Assumes the processor
// never raises read and write together.
module susp_bus_path
    import susp_pkg::*;
#(
    parameter int                ADDR_W    = 22,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = {ADDR_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  susp_state_e       state_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              cpu_rd_i,
    input  logic              cpu_wr_i,
    input  logic              mem_rdy_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic              halt_i,
    output logic              trig_o,
    output logic              host_req_o,
    output logic              bus_host_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              cpu_rdy_o,
    output logic [DATA_W-1:0] cpu_rdata_o
);

    logic is_mbox;
    logic path_open;
    logic fwd_rd;
    logic fwd_wr;
    logic in_complete;

    // Decode the mailbox address and whether the processor path is open.
    always_comb begin
        is_mbox     = (cpu_addr_i == MBOX_ADDR);
        path_open   = (state_i == ST_IDLE) && !halt_i;
        in_complete = (state_i == ST_COMPLETE);
        fwd_rd      = path_open && cpu_rd_i && !is_mbox;
        fwd_wr      = path_open && cpu_wr_i;
    end

    // Memory strobes and the suspension trigger.
    always_comb begin
        mem_rd_o = fwd_rd;
        mem_wr_o = fwd_wr;
        trig_o   = path_open && cpu_rd_i && is_mbox;
    end

    // Ready and data back to the processor.
    always_comb begin
        cpu_rdy_o   = in_complete || ((fwd_rd || fwd_wr) && mem_rdy_i);
        cpu_rdata_o = in_complete ? status_i : mem_rdata_i;
    end

    // Bus ownership: host during turnaround, waiting, or halt.
    always_comb begin
        host_req_o = (state_i == ST_WAIT);
        bus_host_o = halt_i || (state_i == ST_GRANT) || (state_i == ST_WAIT);
    end

    // Mailbox reads are never forwarded and only complete in the completion cycle.
    assert_mbox_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && is_mbox && !in_complete) |-> (!cpu_rdy_o && !mem_rd_o));

    // Halt gives the host the bus and blocks forwarding.
    assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> (bus_host_o && !mem_rd_o && !mem_wr_o && !trig_o));

endmodule

// File: rtl/rd_suspend_ctrl.sv
// Top of the suspend-by-read handshake controller.
// Joins the sequencer, the return-word register and the access path. The
// host side is assumed to raise done only after it has seen host_req, and
// to write the mailbox word while host_req is high.
module rd_suspend_ctrl
    import susp_pkg::*;
#(
    parameter int                ADDR_W    = 22,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = {ADDR_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic              cpu_rdy,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_rdy,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              ctl_halt,
    input  logic              host_done,
    input  logic              host_mbox_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_req,
    output logic              bus_sel_host
);

    susp_state_e       state;
    logic              trig;
    logic [DATA_W-1:0] ret_word;

    susp_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .done_i  (host_done),
        .state_o (state)
    );

    susp_status_reg #(.DATA_W(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (host_req),
        .we_i     (host_mbox_we),
        .wdata_i  (host_wdata),
        .word_o   (ret_word)
    );

    susp_bus_path #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MBOX_ADDR (MBOX_ADDR)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .cpu_addr_i  (cpu_addr),
        .cpu_rd_i    (cpu_rd),
        .cpu_wr_i    (cpu_wr),
        .mem_rdy_i   (mem_rdy),
        .mem_rdata_i (mem_rdata),
        .status_i    (ret_word),
        .halt_i      (ctl_halt),
        .trig_o      (trig),
        .host_req_o  (host_req),
        .bus_host_o  (bus_sel_host),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .cpu_rdy_o   (cpu_rdy),
        .cpu_rdata_o (cpu_rdata)
    );

    // host_req only rises after a cycle in which the bus was already handed over.
    assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_req) |-> $past(bus_sel_host));

    // A triggering mailbox read hands the bus over without yet raising the request.
    assert_grant_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (bus_sel_host && !host_req));

    // While suspended the processor sees no completion.
    assert_no_rdy_while_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> !cpu_rdy);

endmodule

// File: tb/rd_suspend_ctrl_bench.sv
module rd_suspend_ctrl_bench;

    localparam int            AW = 6;
    localparam int            DW = 16;
    localparam logic [AW-1:0] MB = 6'h2A;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] cpu_addr;
    logic          cpu_rd, cpu_wr, cpu_rdy, mem_rd, mem_wr, mem_rdy;
    logic [DW-1:0] cpu_rdata, mem_rdata, host_wdata;
    logic          ctl_halt, host_done, host_mbox_we, host_req, bus_sel_host;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state: 0 idle, 1 turnaround, 2 waiting, 3 completion.
    int            ms = 0;
    logic [DW-1:0] m_word = '0;
    logic          m_done_q = 1'b0;

    always #10 clk = ~clk;

    rd_suspend_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MBOX_ADDR(MB)) u_rd_suspend_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .ctl_halt(ctl_halt),
        .host_done(host_done), .host_mbox_we(host_mbox_we), .host_wdata(host_wdata),
        .host_req(host_req), .bus_sel_host(bus_sel_host)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model's expectation for this cycle.
    task automatic compare_all();
        logic  is_mb, open_p, e_bus, e_req, e_mrd, e_mwr, e_rdy;
        string tg;
        is_mb  = (cpu_addr == MB);
        open_p = (ms == 0) && !ctl_halt;
        e_bus  = ctl_halt || ms == 1 || ms == 2;
        e_req  = (ms == 2);
        e_mrd  = open_p && cpu_rd && !is_mb;
        e_mwr  = open_p && cpu_wr;
        e_rdy  = (ms == 3) || (open_p && mem_rdy && ((cpu_rd && !is_mb) || cpu_wr));
        if (ms == 3)                 tg = "R6";
        else if (ms == 1 || ms == 2) tg = "R4";
        else if (ctl_halt)           tg = "R8";
        else if (cpu_rd && is_mb)    tg = "R3";
        else                         tg = "R2";
        chk(tg, "bus_sel_host", 32'(bus_sel_host), 32'(e_bus));
        chk(tg, "host_req",     32'(host_req),     32'(e_req));
        chk(tg, "mem_rd",       32'(mem_rd),       32'(e_mrd));
        chk(tg, "mem_wr",       32'(mem_wr),       32'(e_mwr));
        chk(tg, "cpu_rdy",      32'(cpu_rdy),      32'(e_rdy));
        if (e_rdy) chk(tg, "cpu_rdata", 32'(cpu_rdata), 32'((ms == 3) ? m_word : mem_rdata));
    endtask

    // Advance the model on a clock edge using the inputs held over it.
    task automatic model_edge();
        if (!rst_n) begin
            ms = 0; m_word = '0; m_done_q = 1'b0;
        end else begin
            if (ms == 2 && host_mbox_we) m_word = host_wdata;
            case (ms)
                0: if (cpu_rd && cpu_addr == MB && !ctl_halt) ms = 1;
                1: ms = 2;
                2: if (host_done && !m_done_q) ms = 3;
                default: ms = 0;
            endcase
            m_done_q = host_done;
        end
    endtask

    task automatic step();
        #4;
        compare_all();
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic quiet();
        cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; mem_rdy = 0; mem_rdata = '0;
        ctl_halt = 0; host_mbox_we = 0; host_wdata = '0;
    endtask

    task automatic start_suspend();
        cpu_rd = 1; cpu_addr = MB;
        step(); step();
    endtask

    initial begin
        #(20 * 200000);
        n_tests++; n_fail++;
        $display("FAIL R6 watchdog act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        quiet(); host_done = 0; rst_n = 0;
        step(); step();
        rst_n = 1; #2;
        chk("R1", "host_req", 32'(host_req), 32'd0);
        chk("R1", "bus_sel_host", 32'(bus_sel_host), 32'd0);
        step();

        // R2 pass-through read and write
        cpu_rd = 1; cpu_addr = 6'h05; mem_rdy = 1; mem_rdata = 16'h1234; #2;
        chk("R2", "mem_rd", 32'(mem_rd), 32'd1);
        chk("R2", "cpu_rdy", 32'(cpu_rdy), 32'd1);
        chk("R2", "cpu_rdata", 32'(cpu_rdata), 32'h1234);
        step();
        cpu_rd = 0; cpu_wr = 1; cpu_addr = MB; #2;
        chk("R2", "mem_wr mailbox addr", 32'(mem_wr), 32'd1);
        step();
        quiet();

        // R3/R4 suspension with no host write; R1 word is zero
        cpu_rd = 1; cpu_addr = MB; mem_rdy = 1; #2;
        chk("R3", "mem_rd", 32'(mem_rd), 32'd0);
        chk("R3", "cpu_rdy", 32'(cpu_rdy), 32'd0);
        step(); #2;
        chk("R4", "bus_sel_host turnaround", 32'(bus_sel_host), 32'd1);
        chk("R4", "host_req turnaround", 32'(host_req), 32'd0);
        step(); #2;
        chk("R4", "host_req raised", 32'(host_req), 32'd1);
        step(); step(); step();
        host_done = 1; step(); #2;
        chk("R1", "cpu_rdy complete", 32'(cpu_rdy), 32'd1);
        chk("R1", "reset word", 32'(cpu_rdata), 32'd0);
        cpu_rd = 0; step(); #2;
        chk("R6", "single completion", 32'(cpu_rdy), 32'd0);
        step();

        // R5 write outside suspension ignored; R7 held done
        host_mbox_we = 1; host_wdata = 16'hFFFF; step();
        host_mbox_we = 0;
        start_suspend();
        for (int i = 0; i < 3; i++) begin
            #2;
            chk("R7", "held done no completion", 32'(cpu_rdy), 32'd0);
            chk("R7", "held done host_req", 32'(host_req), 32'd1);
            step();
        end
        host_mbox_we = 1; host_wdata = 16'h1111; step();
        host_wdata = 16'h2222; step();
        host_mbox_we = 0; host_done = 0; step();
        host_done = 1; step(); #2;
        chk("R5", "last accepted write", 32'(cpu_rdata), 32'h2222);
        cpu_rd = 0; host_done = 0; step(); step();

        // R10 persistence
        start_suspend();
        host_done = 1; step(); #2;
        chk("R10", "word persists", 32'(cpu_rdata), 32'h2222);
        cpu_rd = 0; host_done = 0; step();

        // R6 write in the same cycle as the done edge
        start_suspend();
        host_mbox_we = 1; host_wdata = 16'h5A5A; host_done = 1; step(); #2;
        chk("R6", "same-cycle write", 32'(cpu_rdata), 32'h5A5A);
        host_mbox_we = 0; cpu_rd = 0; host_done = 0; step();

        // R8 halt
        ctl_halt = 1; cpu_rd = 1; cpu_addr = 6'h03; mem_rdy = 1; #2;
        chk("R8", "cpu_rdy", 32'(cpu_rdy), 32'd0);
        chk("R8", "mem_rd", 32'(mem_rd), 32'd0);
        chk("R8", "bus_sel_host", 32'(bus_sel_host), 32'd1);
        step();
        cpu_addr = MB; step(); step(); step(); #2;
        chk("R8", "no suspension under halt", 32'(host_req), 32'd0);
        ctl_halt = 0; cpu_rd = 0; step();

        // R9 reset mid suspension
        start_suspend(); #2;
        chk("R9", "waiting before reset", 32'(host_req), 32'd1);
        rst_n = 0; cpu_rd = 0; step();
        rst_n = 1; #2;
        chk("R9", "host_req after reset", 32'(host_req), 32'd0);
        chk("R9", "bus_sel_host after reset", 32'(bus_sel_host), 32'd0);
        step();

        // Random mix
        for (int c = 0; c < 4000; c++) begin
            int r;
            rst_n    = ($urandom % 256) != 0;
            ctl_halt = ($urandom % 16) == 0;
            r = $urandom % 4;
            cpu_rd   = (r == 0);
            cpu_wr   = (r == 1);
            cpu_addr = (($urandom % 3) == 0) ? MB : AW'($urandom);
            mem_rdy  = 1'($urandom);
            mem_rdata = DW'($urandom);
            if (($urandom % 6) == 0) host_done = ~host_done;
            host_mbox_we = ($urandom % 4) == 0;
            host_wdata   = DW'($urandom);
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule